// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Gate

This block sits between the divided clock sources of a clock generator and its output pins. It gates a set of output clocks: a stoppable PCI group, a free-running PCI group with per-output stop opt-in, a 66 MHz group, two 48 MHz outputs, a reference output and a set of differential CPU pairs. It acts on a PCI-stop pin, a software run bit and an active-low power-down pin. Every output stops low and restarts cleanly, so no shortened high pulse ever reaches a pin.

All logic runs on one fast sampling clock `clk`. Each source clock arrives as a level on an input and is sampled by `clk`. Each output is a registered copy of its source, ANDed with a per-output gate. That gate may only change while the sampled source is low. The two asynchronous pins pass through a two-flop synchronizer before they touch any gate. Power-down is qualified on rising edges of the CPU source. While it is active, the CPU true lines are parked high with a boost flag set and the complement lines are released.

Top module: `clkgate_ctrl`

## Requirements
- R1: PCI-stop is in force when the synchronized `pci_stop_n_i` is 0 or when `sw_pci_run_i` is 0. Either condition alone is enough.
- R2: Under PCI-stop, every `pci_o` bit stops low. A `pcif_o` bit stops only when its `pcif_stoppable_i` bit is 1. With the bit at 0 it keeps running.
- R3: Power-down starts only after two consecutive rising edges of `src_cpu_i` both sample the synchronized power-down pin low. A low seen on a single rising edge does nothing.
- R4: While power-down is active, all non-CPU outputs (`pci_o`, `pcif_o`, `m66_o`, `usb_o`, `dot_o`, `ref_o`) stay low from their source's next low phase onward.
- R5: While power-down is active, `cpu_t_o` is all ones, `cpu_boost_o` is 1, `cpu_c_oe_o` is 0 and `cpu_c_o` is all zeros. Outside power-down, `cpu_boost_o` is 0 and `cpu_c_oe_o` is 1.
- R6: An enable input at 0 holds its output low (not tri-stated), whatever the stop modes are.
- R7: Each output equals its source sampled one `clk` earlier, ANDed with a gate. The gate takes a new value only on a `clk` edge where the source is sampled low. Every high pulse at an output is therefore full width.
- R8: `pci_stop_n_i` and `pd_n_i` pass through two flops before they take effect. After reset the synchronized pins read as inactive (high).
- R9: Power-down ends on the first rising edge of `src_cpu_i` that samples the synchronized power-down pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all sources and state |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_stop_n_i | input | 1 | Asynchronous PCI-stop pin, active low |
| pd_n_i | input | 1 | Asynchronous power-down pin, active low |
| sw_pci_run_i | input | 1 | Software PCI run bit; 0 requests PCI-stop |
| en_pci_i | input | N_PCI | Enables for the stoppable PCI outputs |
| en_pcif_i | input | N_PCIF | Enables for the free-running PCI outputs |
| pcif_stoppable_i | input | N_PCIF | 1: this free-running PCI output obeys PCI-stop |
| en_m66_i | input | N_M66 | Enables for the 66 MHz outputs |
| en_usb_i | input | 1 | Enable for the USB 48 MHz output |
| en_dot_i | input | 1 | Enable for the DOT 48 MHz output |
| en_ref_i | input | 1 | Enable for the reference output |
| en_cpu_i | input | N_CPU | Enables for the CPU pairs |
| src_pci_i | input | 1 | 33 MHz source level |
| src_m66_i | input | 1 | 66 MHz source level |
| src_48_i | input | 1 | 48 MHz source level |
| src_ref_i | input | 1 | Reference source level |
| src_cpu_i | input | 1 | CPU source level |
| pci_o | output | N_PCI | Gated stoppable PCI clocks |
| pcif_o | output | N_PCIF | Gated free-running PCI clocks |
| m66_o | output | N_M66 | Gated 66 MHz clocks |
| usb_o | output | 1 | Gated USB clock |
| dot_o | output | 1 | Gated DOT clock |
| ref_o | output | 1 | Gated reference clock |
| cpu_t_o | output | N_CPU | CPU true drive level |
| cpu_c_o | output | N_CPU | CPU complement drive level |
| cpu_boost_o | output | 1 | 1: true lines driven high at doubled current |
| cpu_c_oe_o | output | 1 | Complement drive enable; 0 leaves them floating |

## Verification
The bench builds the block with its defaults: seven stoppable PCI outputs, three free-running PCI outputs, six 66 MHz outputs and four CPU pairs. The source levels have periods of 6, 4, 2, 10 and 2 `clk` cycles. Because these periods differ, stop and power-down requests land in every phase of every source. That exposes gates that close mid-pulse, and it lets a single-rise power-down pulse be told apart from a two-rise one. Three free-running PCI outputs with independent stoppable bits allow mixed flag patterns under both the pin and the software stop.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_ARMED = 2'd1,
    PD_DOWN  = 2'd2
  } pd_state_e;
endpackage

// File: rtl/clkgate_sync2.sv
module clkgate_sync2 #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic allow_i,
  output logic clk_o
);
  logic gate_q, gate_d;
  logic out_q, out_d;

  // the gate may only move while the source is low
  always_comb begin
    gate_d = gate_q;
    if (!src_i) gate_d = allow_i;
    out_d = src_i & gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      out_q  <= out_d;
    end
  end

  assign clk_o = out_q;

  assert_gate_moves_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != $past(gate_q)) |-> !$past(src_i));

  assert_closed_stays_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |=> !clk_o);
endmodule

// File: rtl/clkgate_pd_qual.sv
module clkgate_pd_qual
  import clkgate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_src_i,
  input  logic pd_low_i,
  output logic pd_active_o
);
  pd_state_e st_q, st_d;
  logic      cpu_prev_q;
  logic      cpu_rise;

  assign cpu_rise = cpu_src_i & ~cpu_prev_q;

  always_comb begin
    st_d = st_q;
    if (cpu_rise) begin
      unique case (st_q)
        PD_RUN:   st_d = pd_low_i ? PD_ARMED : PD_RUN;
        PD_ARMED: st_d = pd_low_i ? PD_DOWN  : PD_RUN;
        PD_DOWN:  st_d = pd_low_i ? PD_DOWN  : PD_RUN;
        default:  st_d = PD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PD_RUN;
      cpu_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cpu_prev_q <= cpu_src_i;
    end
  end

  assign pd_active_o = (st_q == PD_DOWN);

  assert_pd_entry_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active_o) |-> $past(pd_low_i));

  assert_pd_exit_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_active_o) |-> !$past(pd_low_i));
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int N_M66  = 6,
  parameter int N_CPU  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pci_stop_n_i,
  input  logic              pd_n_i,
  input  logic              sw_pci_run_i,
  input  logic [N_PCI-1:0]  en_pci_i,
  input  logic [N_PCIF-1:0] en_pcif_i,
  input  logic [N_PCIF-1:0] pcif_stoppable_i,
  input  logic [N_M66-1:0]  en_m66_i,
  input  logic              en_usb_i,
  input  logic              en_dot_i,
  input  logic              en_ref_i,
  input  logic [N_CPU-1:0]  en_cpu_i,
  input  logic              src_pci_i,
  input  logic              src_m66_i,
  input  logic              src_48_i,
  input  logic              src_ref_i,
  input  logic              src_cpu_i,
  output logic [N_PCI-1:0]  pci_o,
  output logic [N_PCIF-1:0] pcif_o,
  output logic [N_M66-1:0]  m66_o,
  output logic              usb_o,
  output logic              dot_o,
  output logic              ref_o,
  output logic [N_CPU-1:0]  cpu_t_o,
  output logic [N_CPU-1:0]  cpu_c_o,
  output logic              cpu_boost_o,
  output logic              cpu_c_oe_o
);
  localparam int N_SLOW = N_PCI + N_PCIF + N_M66 + 3;

  logic [1:0]       pin_sync;
  logic             pci_stop, pd_active;
  logic [N_CPU-1:0] t_cell, c_cell;

  clkgate_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({pci_stop_n_i, pd_n_i}),
    .q_o  (pin_sync)
  );

  assign pci_stop = ~pin_sync[1] | ~sw_pci_run_i;

  clkgate_pd_qual u_pd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_src_i  (src_cpu_i),
    .pd_low_i   (~pin_sync[0]),
    .pd_active_o(pd_active)
  );

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    clkgate_cell u_cell (
      .clk(clk), .rst_n(rst_n), .src_i(src_pci_i),
      .allow_i(en_pci_i[i] & ~pci_stop & ~pd_active),
      .clk_o(pci_o[i])
    );
  end

  for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif
    clkgate_cell u_cell (
      .clk(clk), .rst_n(rst_n), .src_i(src_pci_i),
      .allow_i(en_pcif_i[i] & ~(pcif_stoppable_i[i] & pci_stop) & ~pd_active),
      .clk_o(pcif_o[i])
    );
  end

  for (genvar i = 0; i < N_M66; i++) begin : g_m66
    clkgate_cell u_cell (
      .clk(clk), .rst_n(rst_n), .src_i(src_m66_i),
      .allow_i(en_m66_i[i] & ~pd_active),
      .clk_o(m66_o[i])
    );
  end

  clkgate_cell u_usb (
    .clk(clk), .rst_n(rst_n), .src_i(src_48_i),
    .allow_i(en_usb_i & ~pd_active), .clk_o(usb_o)
  );
  clkgate_cell u_dot (
    .clk(clk), .rst_n(rst_n), .src_i(src_48_i),
    .allow_i(en_dot_i & ~pd_active), .clk_o(dot_o)
  );
  clkgate_cell u_ref (
    .clk(clk), .rst_n(rst_n), .src_i(src_ref_i),
    .allow_i(en_ref_i & ~pd_active), .clk_o(ref_o)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    clkgate_cell u_t (
      .clk(clk), .rst_n(rst_n), .src_i(src_cpu_i),
      .allow_i(en_cpu_i[i]), .clk_o(t_cell[i])
    );
    clkgate_cell u_c (
      .clk(clk), .rst_n(rst_n), .src_i(~src_cpu_i),
      .allow_i(en_cpu_i[i]), .clk_o(c_cell[i])
    );
  end

  // power-down parks the pair: true high at boosted drive, complement released
  assign cpu_t_o     = pd_active ? {N_CPU{1'b1}} : t_cell;
  assign cpu_c_o     = pd_active ? {N_CPU{1'b0}} : c_cell;
  assign cpu_boost_o = pd_active;
  assign cpu_c_oe_o  = ~pd_active;

  logic [N_SLOW-1:0] slow_bus;
  assign slow_bus = {ref_o, dot_o, usb_o, m66_o, pcif_o, pci_o};

  assert_pd_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && $past(pd_active) && $past(pd_active, 2)) |->
      ((slow_bus & ~$past(slow_bus)) == '0));
endmodule

// File: tb/clkgate_ctrl_tb_top.sv
module clkgate_ctrl_tb_top;
  localparam int NP = 7, NF = 3, NM = 6, NC = 4, NS = NP + NF + NM + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic pci_stop_n, pd_n, sw_run;
  logic [NP-1:0] en_pci;
  logic [NF-1:0] en_pcif, stoppable;
  logic [NM-1:0] en_m66;
  logic en_usb, en_dot, en_ref;
  logic [NC-1:0] en_cpu;
  logic s_pci, s_m66, s_48, s_ref, s_cpu;
  logic [NP-1:0] pci_o;
  logic [NF-1:0] pcif_o;
  logic [NM-1:0] m66_o;
  logic usb_o, dot_o, ref_o, boost_o, c_oe_o;
  logic [NC-1:0] cpu_t_o, cpu_c_o;

  clkgate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pci_stop_n_i(pci_stop_n), .pd_n_i(pd_n),
    .sw_pci_run_i(sw_run), .en_pci_i(en_pci), .en_pcif_i(en_pcif),
    .pcif_stoppable_i(stoppable), .en_m66_i(en_m66), .en_usb_i(en_usb),
    .en_dot_i(en_dot), .en_ref_i(en_ref), .en_cpu_i(en_cpu),
    .src_pci_i(s_pci), .src_m66_i(s_m66), .src_48_i(s_48),
    .src_ref_i(s_ref), .src_cpu_i(s_cpu),
    .pci_o(pci_o), .pcif_o(pcif_o), .m66_o(m66_o), .usb_o(usb_o),
    .dot_o(dot_o), .ref_o(ref_o), .cpu_t_o(cpu_t_o), .cpu_c_o(cpu_c_o),
    .cpu_boost_o(boost_o), .cpu_c_oe_o(c_oe_o)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  string tag = "R8";
  bit done = 0;

  // expected-value model built from the requirements
  logic ps1, ps2, pd1, pd2, cprev;
  int   pst;
  logic [NS-1:0] g_m, o_m;
  logic [NC-1:0] gt_m, ot_m, gc_m, oc_m;

  function automatic logic [NS-1:0] src_vec(logic p, logic m, logic u, logic r);
    return {r, u, u, {NM{m}}, {NF{p}}, {NP{p}}};
  endfunction

  function automatic logic [NS-1:0] allow_vec(logic stop, logic down);
    logic [NF-1:0] f;
    f = en_pcif & ~(stoppable & {NF{stop}});
    return {en_ref, en_dot, en_usb, en_m66, f, en_pci & {NP{~stop}}} & {NS{~down}};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps1 <= 1; ps2 <= 1; pd1 <= 1; pd2 <= 1; cprev <= 0; pst <= 0;
      g_m <= '0; o_m <= '0; gt_m <= '0; ot_m <= '0; gc_m <= '0; oc_m <= '0;
    end else begin
      logic [NS-1:0] sv, av;
      sv = src_vec(s_pci, s_m66, s_48, s_ref);
      av = allow_vec(~ps2 | ~sw_run, pst == 2);
      ps1 <= pci_stop_n; ps2 <= ps1; pd1 <= pd_n; pd2 <= pd1;
      cprev <= s_cpu;
      if (s_cpu && !cprev) begin
        if (!pd2) pst <= (pst == 0) ? 1 : 2;
        else pst <= 0;
      end
      o_m <= sv & g_m;
      g_m <= (sv & g_m) | (~sv & av);
      ot_m <= {NC{s_cpu}} & gt_m;
      if (!s_cpu) gt_m <= en_cpu;
      oc_m <= {NC{~s_cpu}} & gc_m;
      if (s_cpu) gc_m <= en_cpu;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    logic dn;
    dn = (pst == 2);
    chk("non-cpu outputs", 32'({ref_o, dot_o, usb_o, m66_o, pcif_o, pci_o}), 32'(o_m));
    chk("cpu true", 32'(cpu_t_o), dn ? 32'hF : 32'(ot_m));
    chk("cpu comp", 32'(cpu_c_o), dn ? 32'h0 : 32'(oc_m));
    chk("boost/oe", 32'({boost_o, c_oe_o}), dn ? 32'h2 : 32'h1);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cyc++;
      check_all();
      s_pci = (cyc % 6) < 3;
      s_m66 = (cyc % 4) < 2;
      s_48  = cyc[0];
      s_ref = (cyc % 10) < 5;
      s_cpu = ~cyc[0];
    end
  endtask

  task automatic all_on();
    en_pci = '1; en_pcif = '1; en_m66 = '1; en_usb = 1; en_dot = 1;
    en_ref = 1; en_cpu = '1; stoppable = '0; sw_run = 1;
    pci_stop_n = 1; pd_n = 1;
  endtask

  initial begin
    void'($urandom(32'd2718));
    all_on();
    s_pci = 0; s_m66 = 0; s_48 = 0; s_ref = 0; s_cpu = 0;
    repeat (3) @(negedge clk);
    tag = "R8"; // reset state: all low, pair released normally
    chk("reset outputs", 32'({ref_o, dot_o, usb_o, m66_o, pcif_o, pci_o}), 32'h0);
    chk("reset boost/oe", 32'({boost_o, c_oe_o}), 32'h1);
    rst_n = 1;
    tag = "R7"; step(60);
    tag = "R2"; pci_stop_n = 0; stoppable = 3'b010; step(50);
    tag = "R8"; pci_stop_n = 1; step(4);
    tag = "R1"; sw_run = 0; stoppable = 3'b101; step(50);
    tag = "R2"; stoppable = 3'b000; step(30); sw_run = 1; step(20);
    tag = "R3"; pd_n = 0; @(negedge clk); cyc++; check_all(); pd_n = 1; step(30);
    tag = "R4"; pd_n = 0; step(40);
    tag = "R5"; step(20);
    tag = "R9"; pd_n = 1; step(30);
    tag = "R6"; en_pci = 7'h55; en_m66 = 6'h0A; en_ref = 0; en_cpu = 4'h6; step(60);
    tag = "R6";
    for (int blk = 0; blk < 120; blk++) begin
      en_pci = NP'($urandom); en_pcif = NF'($urandom); stoppable = NF'($urandom);
      en_m66 = NM'($urandom); en_usb = 1'($urandom); en_dot = 1'($urandom);
      en_ref = 1'($urandom); en_cpu = NC'($urandom);
      sw_run = ($urandom % 4) != 0;
      pci_stop_n = ($urandom % 3) != 0;
      pd_n = ($urandom % 4) != 0;
      step(1 + ($urandom % 30));
    end
    pd_n = 1; all_on(); tag = "R9"; step(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule